// File: doc/BRIEF.md
# SPI Command Slave for a CAN-Style Register File

This block is the serial front end of a small CAN-style controller. A host reaches a 128-byte register file over a mode-0 SPI link, most significant bit first. Each chip-select-low window is one transaction. Its first byte selects the operation. The operations are: plain write, plain read, masked modify, status read, transmit-buffer load, receive-buffer read, transmit request, and soft reset. The register file stands in for the controller core. A harness port can write any location directly, for example to fill a receive buffer or to raise its interrupt flags.

The SPI pins are sampled in the system clock domain through synchronizers. SCLK must therefore be several times slower than `clk`. Read data for a byte is loaded on the SCLK falling edge that follows the previous byte. `spi_miso_oe` enables the pad driver only while chip-select is low. Two side outputs report events to the rest of the chip: a per-buffer one-cycle transmit strobe, and a one-cycle soft-reset pulse.

Top module: `spi_regfile_slave`

## Requirements
- R1: `spi_miso_oe` is 1 while the synchronized chip-select is low and 0 otherwise. The first byte of every frame is decoded as the opcode.
- R2: Opcode 0x02, then an address byte, then data bytes, writes consecutive locations. Address bit 7 is ignored. The pointer wraps from 0x7F to 0x00.
- R3: Opcode 0x03, then an address byte, returns the byte at the pointer on each following byte. The pointer increments after each returned byte.
- R4: Opcode 0x05, then address, mask and data bytes, updates only the bits whose mask bit is 1: new = (old & ~mask) | (data & mask).
- R5: Opcodes 0x40, 0x42 and 0x44 load transmit buffer n = op[2:1] with no address byte. The data bytes go to address ((n+3)<<4)+1 and the locations after it.
- R6: Opcode 0x80|m, with m non-zero and one bit per buffer, sets bit 3 of the control byte at (n+3)<<4 for each set bit n. It also pulses `tx_start[n]` for exactly one cycle.
- R7: Opcodes 0x90 and 0x94 stream receive buffer n = op[2] from address ((n+6)<<4)+1 with auto-increment. When chip-select rises, bit n of the flag byte at 0x2C is cleared.
- R8: Opcode 0xA0 returns a status byte on every following byte. Bits 1:0 are flag-byte bits 1:0 (receive buffers full). Bits 4:2 are the request bits of transmit buffers 0..2. Bits 7:5 are 0.
- R9: Opcode 0xC0 alone in a frame restores defaults when chip-select rises and pulses `soft_rst` for one cycle. The default is 0x87 at 0x0F and 0x00 everywhere else. If any further byte follows in the same frame, nothing is reset.
- R10: Location 0x0E reads back bits 7:5 of 0x0F in bits 7:5, with bits 4:0 zero. SPI writes to 0x0E have no effect.
- R11: A byte cut short by chip-select rising is discarded and does not write anything.
- R12: When `poke_en` is 1, `poke_data` is written to `poke_addr` on that clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | SPI clock, idle low |
| spi_cs_n | input | 1 | SPI chip-select, active low |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| spi_miso_oe | output | 1 | Output enable for the MISO pad driver |
| poke_en | input | 1 | Harness write strobe |
| poke_addr | input | 7 | Harness write address |
| poke_data | input | 8 | Harness write data |
| tx_start | output | 3 | One-cycle transmit request strobe per buffer |
| soft_rst | output | 1 | One-cycle pulse when a soft reset is applied |

## Verification
The bench attacks these corner cases:
- Pointer wrap from 0x7F to 0x00 with address bit 7 set: a design that kept eight pointer bits would write beyond the array or miss the low address.
- A frame cut after four bits of a data byte: a design that kept the partial byte would corrupt the next location.
- A reset opcode followed by one more byte: a design that acted at the opcode instead of at frame end would wipe the transmit request bits.
- The receive-buffer read: a design that cleared the wrong flag, or cleared it before the frame ended, shows up in the later flag and status reads.
- The mode mirror: writing 0x0E must not disturb the mirror of the request field, and a write to 0x0F must appear in it at once.

// File: rtl/spicmd_pkg.sv
package spicmd_pkg;
  localparam int ADDR_W    = 7;
  localparam int DEPTH     = 1 << ADDR_W;
  localparam int BYTE_W    = 8;
  localparam int CNT_W     = $clog2(BYTE_W);
  localparam int NUM_TX    = 3;
  localparam int NUM_RX    = 2;
  localparam int TXREQ_BIT = 3;
  localparam int MODE_LSB  = 5;

  localparam logic [BYTE_W-1:0] OP_WRITE  = 8'h02;
  localparam logic [BYTE_W-1:0] OP_READ   = 8'h03;
  localparam logic [BYTE_W-1:0] OP_MODIFY = 8'h05;
  localparam logic [BYTE_W-1:0] OP_STATUS = 8'hA0;
  localparam logic [BYTE_W-1:0] OP_RESET  = 8'hC0;

  localparam logic [ADDR_W-1:0] A_MODE_STAT = 7'h0E;
  localparam logic [ADDR_W-1:0] A_MODE_CTRL = 7'h0F;
  localparam logic [ADDR_W-1:0] A_IRQ_FLAGS = 7'h2C;
  localparam logic [BYTE_W-1:0] CTRL_RESET_VAL = 8'h87;

  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [ADDR_W-1:0] addr_t;

  typedef enum logic [3:0] {
    ST_OPC, ST_ADDR, ST_RDSTREAM, ST_WRSTREAM, ST_MASK,
    ST_MODDATA, ST_STATUS, ST_RSTWAIT, ST_IDLE
  } eng_state_e;

  typedef enum logic [1:0] {AK_WRITE, AK_READ, AK_MODIFY} addr_kind_e;

  // Masked merge used by both plain writes (mask all ones) and modify.
  function automatic byte_t merge_masked(byte_t old_v, byte_t new_v, byte_t mask);
    return (old_v & ~mask) | (new_v & mask);
  endfunction

  function automatic addr_t tx_ctrl_addr(int unsigned idx);
    return addr_t'((idx + 3) << 4);
  endfunction

  function automatic addr_t rx_ctrl_addr(int unsigned idx);
    return addr_t'((idx + 6) << 4);
  endfunction

  function automatic logic op_is_load(byte_t op);
    return (op[7:3] == 5'b01000) && !op[0] && (int'(op[2:1]) < NUM_TX);
  endfunction

  function automatic logic op_is_rts(byte_t op);
    return (op[7:3] == 5'b10000) && (op[2:0] != 3'b000);
  endfunction

  function automatic logic op_is_rxread(byte_t op);
    return (op[7:3] == 5'b10010) && (op[1:0] == 2'b00);
  endfunction

  function automatic byte_t status_pack(logic [NUM_RX-1:0] rxf, logic [NUM_TX-1:0] txq);
    byte_t s;
    s = '0;
    s[NUM_RX-1:0]      = rxf;
    s[NUM_RX +: NUM_TX] = txq;
    return s;
  endfunction

  function automatic byte_t reg_default(addr_t a);
    return (a == A_MODE_CTRL) ? CTRL_RESET_VAL : '0;
  endfunction
endpackage

// File: rtl/spicmd_shifter.sv
module spicmd_shifter
  import spicmd_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sclk,
  input  logic             cs_n,
  input  logic             mosi,
  input  byte_t            tx_byte,
  output logic             byte_done,
  output byte_t            rx_byte,
  output logic             frame_start,
  output logic             frame_end,
  output logic             cs_active,
  output logic             miso_bit,
  output logic [CNT_W-1:0] bit_cnt
);
  logic [SYNC_STAGES-1:0] sclk_q, cs_q, mosi_q;
  logic sclk_s, cs_s, mosi_s, sclk_d, cs_d;
  logic sclk_rise, sclk_fall;
  byte_t in_sr, out_sr;

  assign sclk_s = sclk_q[SYNC_STAGES-1];
  assign cs_s   = cs_q[SYNC_STAGES-1];
  assign mosi_s = mosi_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= '0;
      cs_q   <= '1;
      mosi_q <= '0;
      sclk_d <= 1'b0;
      cs_d   <= 1'b1;
    end else begin
      sclk_q <= {sclk_q[SYNC_STAGES-2:0], sclk};
      cs_q   <= {cs_q[SYNC_STAGES-2:0], cs_n};
      mosi_q <= {mosi_q[SYNC_STAGES-2:0], mosi};
      sclk_d <= sclk_s;
      cs_d   <= cs_s;
    end
  end

  assign sclk_rise   = sclk_s & ~sclk_d;
  assign sclk_fall   = ~sclk_s & sclk_d;
  assign frame_start = cs_d & ~cs_s;
  assign frame_end   = cs_s & ~cs_d;
  assign cs_active   = ~cs_s;
  assign miso_bit    = out_sr[BYTE_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt   <= '0;
      in_sr     <= '0;
      out_sr    <= '0;
      rx_byte   <= '0;
      byte_done <= 1'b0;
    end else begin
      byte_done <= 1'b0;
      if (cs_s) begin
        // idle or frame cut: any partial byte is dropped here
        bit_cnt <= '0;
        out_sr  <= '0;
      end else begin
        if (sclk_rise) begin
          in_sr <= {in_sr[BYTE_W-2:0], mosi_s};
          if (bit_cnt == CNT_W'(BYTE_W - 1)) begin
            bit_cnt   <= '0;
            byte_done <= 1'b1;
            rx_byte   <= {in_sr[BYTE_W-2:0], mosi_s};
          end else begin
            bit_cnt <= bit_cnt + 1'b1;
          end
        end
        if (sclk_fall) begin
          if (bit_cnt == '0) out_sr <= tx_byte;
          else               out_sr <= {out_sr[BYTE_W-2:0], 1'b0};
        end
      end
    end
  end
endmodule

// File: rtl/spicmd_regs.sv
module spicmd_regs
  import spicmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              wr_en,
  input  addr_t             wr_addr,
  input  byte_t             wr_data,
  input  byte_t             wr_mask,
  input  logic              poke_en,
  input  addr_t             poke_addr,
  input  byte_t             poke_data,
  input  logic [NUM_TX-1:0] txreq_set,
  input  logic [NUM_RX-1:0] rxflag_clr,
  input  addr_t             rd_addr,
  output byte_t             rd_data,
  output byte_t             status_byte,
  output logic [NUM_TX-1:0] txreq_bits,
  output logic [NUM_RX-1:0] rx_flags
);
  byte_t mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= reg_default(addr_t'(i));
    end else if (soft_rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= reg_default(addr_t'(i));
    end else begin
      if (poke_en) mem[poke_addr] <= poke_data;
      if (wr_en && (wr_addr != A_MODE_STAT))
        mem[wr_addr] <= merge_masked(mem[wr_addr], wr_data, wr_mask);
      for (int t = 0; t < NUM_TX; t++)
        if (txreq_set[t]) mem[tx_ctrl_addr(t)][TXREQ_BIT] <= 1'b1;
      for (int r = 0; r < NUM_RX; r++)
        if (rxflag_clr[r]) mem[A_IRQ_FLAGS][r] <= 1'b0;
    end
  end

  // The mode status location mirrors the request field of the control byte.
  always_comb begin
    if (rd_addr == A_MODE_STAT)
      rd_data = {mem[A_MODE_CTRL][BYTE_W-1:MODE_LSB], {MODE_LSB{1'b0}}};
    else
      rd_data = mem[rd_addr];
  end

  for (genvar t = 0; t < NUM_TX; t++) begin : g_txreq
    assign txreq_bits[t] = mem[tx_ctrl_addr(t)][TXREQ_BIT];
  end

  assign rx_flags    = mem[A_IRQ_FLAGS][NUM_RX-1:0];
  assign status_byte = status_pack(rx_flags, txreq_bits);
endmodule

// File: rtl/spicmd_engine.sv
module spicmd_engine
  import spicmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              frame_end,
  input  logic              byte_done,
  input  byte_t             rx_byte,
  input  byte_t             rd_data,
  input  byte_t             status_byte,
  output addr_t             rd_addr,
  output byte_t             tx_byte,
  output logic              wr_en,
  output addr_t             wr_addr,
  output byte_t             wr_data,
  output byte_t             wr_mask,
  output logic [NUM_TX-1:0] txreq_set,
  output logic [NUM_RX-1:0] rxflag_clr,
  output logic              soft_rst
);
  eng_state_e        state;
  addr_kind_e        kind;
  addr_t             ptr;
  byte_t             mask_q;
  logic [NUM_RX-1:0] clr_pend;

  always_comb begin
    if (state == ST_OPC)       rd_addr = rx_ctrl_addr(int'(rx_byte[2])) + addr_t'(1);
    else if (state == ST_ADDR) rd_addr = rx_byte[ADDR_W-1:0];
    else                       rd_addr = ptr;
  end

  assign wr_en     = byte_done && ((state == ST_WRSTREAM) || (state == ST_MODDATA));
  assign wr_addr   = ptr;
  assign wr_data   = rx_byte;
  assign wr_mask   = (state == ST_MODDATA) ? mask_q : '1;
  assign txreq_set = (byte_done && (state == ST_OPC) && op_is_rts(rx_byte))
                     ? rx_byte[NUM_TX-1:0] : '0;
  assign rxflag_clr = frame_end ? clr_pend : '0;
  assign soft_rst   = frame_end && (state == ST_RSTWAIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      kind     <= AK_WRITE;
      ptr      <= '0;
      mask_q   <= '0;
      clr_pend <= '0;
      tx_byte  <= '0;
    end else if (frame_start) begin
      state    <= ST_OPC;
      clr_pend <= '0;
      tx_byte  <= '0;
    end else if (frame_end) begin
      state    <= ST_IDLE;
      clr_pend <= '0;
    end else if (byte_done) begin
      tx_byte <= '0;
      unique case (state)
        ST_OPC: begin
          if (rx_byte == OP_WRITE) begin
            kind <= AK_WRITE; state <= ST_ADDR;
          end else if (rx_byte == OP_READ) begin
            kind <= AK_READ; state <= ST_ADDR;
          end else if (rx_byte == OP_MODIFY) begin
            kind <= AK_MODIFY; state <= ST_ADDR;
          end else if (rx_byte == OP_STATUS) begin
            tx_byte <= status_byte; state <= ST_STATUS;
          end else if (rx_byte == OP_RESET) begin
            state <= ST_RSTWAIT;
          end else if (op_is_load(rx_byte)) begin
            ptr   <= tx_ctrl_addr(int'(rx_byte[2:1])) + addr_t'(1);
            state <= ST_WRSTREAM;
          end else if (op_is_rxread(rx_byte)) begin
            tx_byte <= rd_data;
            ptr     <= rd_addr + addr_t'(1);
            clr_pend[rx_byte[2]] <= 1'b1;
            state   <= ST_RDSTREAM;
          end else begin
            state <= ST_IDLE;
          end
        end
        ST_ADDR: begin
          ptr <= rx_byte[ADDR_W-1:0];
          if (kind == AK_READ) begin
            tx_byte <= rd_data;
            ptr     <= rd_addr + addr_t'(1);
            state   <= ST_RDSTREAM;
          end else if (kind == AK_MODIFY) begin
            state <= ST_MASK;
          end else begin
            state <= ST_WRSTREAM;
          end
        end
        ST_RDSTREAM: begin
          tx_byte <= rd_data;
          ptr     <= ptr + addr_t'(1);
        end
        ST_WRSTREAM: ptr <= ptr + addr_t'(1);
        ST_MASK: begin
          mask_q <= rx_byte;
          state  <= ST_MODDATA;
        end
        ST_STATUS:  tx_byte <= status_byte;
        ST_MODDATA: state <= ST_IDLE;
        ST_RSTWAIT: state <= ST_IDLE;
        default:    state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_regfile_slave.sv
module spi_regfile_slave
  import spicmd_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sclk,
  input  logic              spi_cs_n,
  input  logic              spi_mosi,
  output logic              spi_miso,
  output logic              spi_miso_oe,
  input  logic              poke_en,
  input  logic [ADDR_W-1:0] poke_addr,
  input  logic [BYTE_W-1:0] poke_data,
  output logic [NUM_TX-1:0] tx_start,
  output logic              soft_rst
);
  // named internal events, also observed by the bound checker
  logic              byte_done, frame_start, frame_end, cs_active, miso_bit;
  logic [CNT_W-1:0]  bit_cnt;
  byte_t             rx_byte, tx_byte, rd_data, status_byte, wr_data, wr_mask;
  addr_t             rd_addr, wr_addr;
  logic              wr_en;
  logic [NUM_TX-1:0] txreq_set, txreq_bits;
  logic [NUM_RX-1:0] rxflag_clr, rx_flags;

  spicmd_shifter #(.SYNC_STAGES(SYNC_STAGES)) u_shift (
    .clk(clk), .rst_n(rst_n), .sclk(spi_sclk), .cs_n(spi_cs_n), .mosi(spi_mosi),
    .tx_byte(tx_byte), .byte_done(byte_done), .rx_byte(rx_byte),
    .frame_start(frame_start), .frame_end(frame_end), .cs_active(cs_active),
    .miso_bit(miso_bit), .bit_cnt(bit_cnt)
  );

  spicmd_engine u_eng (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .frame_end(frame_end),
    .byte_done(byte_done), .rx_byte(rx_byte), .rd_data(rd_data),
    .status_byte(status_byte), .rd_addr(rd_addr), .tx_byte(tx_byte),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_mask(wr_mask),
    .txreq_set(txreq_set), .rxflag_clr(rxflag_clr), .soft_rst(soft_rst)
  );

  spicmd_regs u_regs (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_mask(wr_mask),
    .poke_en(poke_en), .poke_addr(poke_addr), .poke_data(poke_data),
    .txreq_set(txreq_set), .rxflag_clr(rxflag_clr), .rd_addr(rd_addr),
    .rd_data(rd_data), .status_byte(status_byte), .txreq_bits(txreq_bits),
    .rx_flags(rx_flags)
  );

  assign spi_miso_oe = cs_active;
  assign spi_miso    = cs_active & miso_bit;
  assign tx_start    = txreq_set;
endmodule

// File: rtl/spicmd_checker.sv
module spicmd_checker
  import spicmd_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              byte_done,
  input logic              frame_end,
  input logic [CNT_W-1:0]  bit_cnt,
  input logic [NUM_TX-1:0] tx_start,
  input logic [NUM_TX-1:0] txreq_bits,
  input logic [NUM_RX-1:0] rxflag_clr,
  input logic [NUM_RX-1:0] rx_flags,
  input logic              soft_rst,
  input logic              miso_oe
);
  AST_BYTE_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |-> miso_oe); // R1
  AST_PARTIAL_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> (bit_cnt == '0)); // R11
  AST_TXREQ_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_start != '0) |=> ((txreq_bits & $past(tx_start)) == $past(tx_start))); // R6
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_start != '0) |=> (tx_start == '0)); // R6
  AST_RXFLAG_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (rxflag_clr != '0) |=> ((rx_flags & $past(rxflag_clr)) == '0)); // R7
  AST_RESET_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |-> frame_end); // R9
endmodule

bind spi_regfile_slave spicmd_checker u_chk (
  .clk(clk), .rst_n(rst_n), .byte_done(byte_done), .frame_end(frame_end),
  .bit_cnt(bit_cnt), .tx_start(tx_start), .txreq_bits(txreq_bits),
  .rxflag_clr(rxflag_clr), .rx_flags(rx_flags), .soft_rst(soft_rst),
  .miso_oe(spi_miso_oe)
);

// File: tb/tb_spi_regfile_slave.sv
module tb_spi_regfile_slave;
  localparam int HALF     = 8;
  localparam int WATCHDOG = 150000;
  // {addr, initial value, mask, data}
  localparam logic [31:0] BM_TABLE [0:5] = '{
    32'h20_3C_F0_AA, 32'h21_FF_00_00, 32'h35_00_FF_5A,
    32'h47_81_81_00, 32'h5C_0F_3C_F0, 32'h7F_55_AA_FF
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso, miso_oe, soft_rst;
  logic poke_en = 1'b0;
  logic [6:0] poke_addr = '0;
  logic [7:0] poke_data = '0;
  logic [2:0] tx_start;

  int n_checks = 0, n_bad = 0;
  int ts_cnt [3];
  int rst_cnt = 0;
  logic oe_in_frame;
  logic [7:0] tx_buf [16];
  logic [7:0] rx_buf [16];

  always #5 clk = ~clk;

  spi_regfile_slave dut (
    .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .spi_miso(miso), .spi_miso_oe(miso_oe), .poke_en(poke_en), .poke_addr(poke_addr),
    .poke_data(poke_data), .tx_start(tx_start), .soft_rst(soft_rst)
  );

  initial for (int i = 0; i < 3; i++) ts_cnt[i] = 0;
  always @(posedge clk) begin
    if (rst_n) begin
      for (int i = 0; i < 3; i++) if (tx_start[i]) ts_cnt[i] = ts_cnt[i] + 1;
      if (soft_rst) rst_cnt = rst_cnt + 1;
    end
  end

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // n bytes from tx_buf; last_bits != 0 cuts the final byte short
  task automatic spi_frame(input int n, input int last_bits);
    @(negedge clk) cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int b = 0; b < n; b++) begin
      automatic int nb = (b == n - 1 && last_bits != 0) ? last_bits : 8;
      automatic logic [7:0] r = '0;
      for (int i = 0; i < nb; i++) begin
        mosi = tx_buf[b][7-i];
        repeat (HALF) @(negedge clk);
        sclk = 1'b1;
        r = {r[6:0], miso};
        if (b == 0 && i == 0) oe_in_frame = miso_oe;
        repeat (HALF) @(negedge clk);
        sclk = 1'b0;
      end
      rx_buf[b] = r;
    end
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    repeat (2 * HALF) @(negedge clk);
  endtask

  task automatic write_reg(input logic [7:0] a, input logic [7:0] v);
    tx_buf[0] = 8'h02; tx_buf[1] = a; tx_buf[2] = v;
    spi_frame(3, 0);
  endtask

  task automatic read_reg(input logic [7:0] a, output logic [7:0] v);
    tx_buf[0] = 8'h03; tx_buf[1] = a; tx_buf[2] = 8'h00;
    spi_frame(3, 0);
    v = rx_buf[2];
  endtask

  task automatic poke(input logic [6:0] a, input logic [7:0] v);
    @(negedge clk) poke_en = 1'b1; poke_addr = a; poke_data = v;
    @(negedge clk) poke_en = 1'b0;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    $display("FAIL watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", n_checks + 1, n_bad + 1);
    $finish;
  end

  initial begin
    logic [7:0] v, expv, a, init, mask, dat;
    int ts0, ts1, ts2, rc;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // reset state
    check("R1 oe idle", {7'b0, miso_oe}, 8'h00);
    check("R6 strobe idle", {5'b0, tx_start}, 8'h00);
    check("R9 pulse idle", {7'b0, soft_rst}, 8'h00);
    read_reg(8'h0E, v); check("R10 mode mirror default", v, 8'h80);
    check("R1 oe during frame", {7'b0, oe_in_frame}, 8'h01);
    check("R1 oe after frame", {7'b0, miso_oe}, 8'h00);
    read_reg(8'h0F, v); check("R10 ctrl default", v, 8'h87);

    // table: write, read back, masked modify, read back
    for (int k = 0; k < 6; k++) begin
      a = BM_TABLE[k][31:24]; init = BM_TABLE[k][23:16];
      mask = BM_TABLE[k][15:8]; dat = BM_TABLE[k][7:0];
      write_reg(a, init);
      read_reg(a, v); check("R2 R3 write readback", v, init);
      tx_buf[0] = 8'h05; tx_buf[1] = a; tx_buf[2] = mask; tx_buf[3] = dat;
      spi_frame(4, 0);
      expv = init ^ ((init ^ dat) & mask);
      read_reg(a, v); check("R4 masked modify", v, expv);
    end

    // burst write with bit 7 set and wrap past 0x7F
    tx_buf[0] = 8'h02; tx_buf[1] = 8'hFE; tx_buf[2] = 8'hA1; tx_buf[3] = 8'hA2; tx_buf[4] = 8'hA3;
    spi_frame(5, 0);
    tx_buf[0] = 8'h03; tx_buf[1] = 8'h7E; tx_buf[2] = 0; tx_buf[3] = 0; tx_buf[4] = 0;
    spi_frame(5, 0);
    check("R3 burst 0", rx_buf[2], 8'hA1);
    check("R3 burst 1", rx_buf[3], 8'hA2);
    check("R2 wrap to 0x00", rx_buf[4], 8'hA3);

    // mode mirror
    write_reg(8'h0E, 8'hFF);
    read_reg(8'h0E, v); check("R10 mirror write ignored", v, 8'h80);
    write_reg(8'h0F, 8'h47);
    read_reg(8'h0E, v); check("R10 mirror follows ctrl", v, 8'h40);

    // partial byte
    tx_buf[0] = 8'h02; tx_buf[1] = 8'h10; tx_buf[2] = 8'h5A; tx_buf[3] = 8'h33;
    spi_frame(4, 4);
    read_reg(8'h10, v); check("R11 full byte kept", v, 8'h5A);
    read_reg(8'h11, v); check("R11 partial byte dropped", v, 8'h00);

    // transmit buffer loads
    tx_buf[0] = 8'h42; tx_buf[1] = 8'h11; tx_buf[2] = 8'h22; tx_buf[3] = 8'h33;
    spi_frame(4, 0);
    tx_buf[0] = 8'h44; tx_buf[1] = 8'h99;
    spi_frame(2, 0);
    read_reg(8'h41, v); check("R5 load buf1 first", v, 8'h11);
    read_reg(8'h43, v); check("R5 load buf1 third", v, 8'h33);
    read_reg(8'h51, v); check("R5 load buf2", v, 8'h99);
    read_reg(8'h40, v); check("R5 ctrl untouched", v, 8'h00);

    // request to send buffers 0 and 2
    ts0 = ts_cnt[0]; ts1 = ts_cnt[1]; ts2 = ts_cnt[2];
    tx_buf[0] = 8'h85;
    spi_frame(1, 0);
    check("R6 strobe buf0", 8'(ts_cnt[0] - ts0), 8'd1);
    check("R6 strobe buf1", 8'(ts_cnt[1] - ts1), 8'd0);
    check("R6 strobe buf2", 8'(ts_cnt[2] - ts2), 8'd1);
    read_reg(8'h30, v); check("R6 req bit buf0", v, 8'h08);
    read_reg(8'h40, v); check("R6 req bit buf1", v, 8'h00);
    read_reg(8'h50, v); check("R6 req bit buf2", v, 8'h08);
    tx_buf[0] = 8'hA0; tx_buf[1] = 8'h00;
    spi_frame(2, 0);
    check("R8 status tx only", rx_buf[1], 8'h14);

    // harness fills receive buffers
    poke(7'h61, 8'hC1); poke(7'h62, 8'hC2); poke(7'h63, 8'hC3);
    poke(7'h71, 8'hD1); poke(7'h72, 8'hD2); poke(7'h2C, 8'h03);
    read_reg(8'h61, v); check("R12 poke visible", v, 8'hC1);
    tx_buf[0] = 8'hA0; tx_buf[1] = 8'h00; tx_buf[2] = 8'h00;
    spi_frame(3, 0);
    check("R8 status rx and tx", rx_buf[1], 8'h17);
    check("R8 status repeats", rx_buf[2], 8'h17);

    tx_buf[0] = 8'h90; tx_buf[1] = 0; tx_buf[2] = 0; tx_buf[3] = 0;
    spi_frame(4, 0);
    check("R7 rx0 byte0", rx_buf[1], 8'hC1);
    check("R7 rx0 byte1", rx_buf[2], 8'hC2);
    check("R7 rx0 byte2", rx_buf[3], 8'hC3);
    read_reg(8'h2C, v); check("R7 rx0 flag cleared", v, 8'h02);
    tx_buf[0] = 8'h94; tx_buf[1] = 0; tx_buf[2] = 0;
    spi_frame(3, 0);
    check("R7 rx1 byte0", rx_buf[1], 8'hD1);
    check("R7 rx1 byte1", rx_buf[2], 8'hD2);
    read_reg(8'h2C, v); check("R7 rx1 flag cleared", v, 8'h00);

    // reset opcode with a trailing byte does nothing
    rc = rst_cnt;
    tx_buf[0] = 8'hC0; tx_buf[1] = 8'h00;
    spi_frame(2, 0);
    check("R9 no pulse with extra byte", 8'(rst_cnt - rc), 8'd0);
    read_reg(8'h30, v); check("R9 state kept", v, 8'h08);

    // reset opcode alone
    tx_buf[0] = 8'hC0;
    spi_frame(1, 0);
    check("R9 one pulse", 8'(rst_cnt - rc), 8'd1);
    read_reg(8'h30, v); check("R9 req cleared", v, 8'h00);
    read_reg(8'h7E, v); check("R9 data cleared", v, 8'h00);
    read_reg(8'h0F, v); check("R9 ctrl default", v, 8'h87);
    read_reg(8'h0E, v); check("R9 R10 mirror default", v, 8'h80);

    $display("test done: total=%0d bad=%0d", n_checks, n_bad);
    $finish;
  end
endmodule